// File: doc/BRIEF.md
# Buffered Word Transfer Unit

This block moves whole words between a small plain memory and a handful of working registers. All moves go through a single one-word buffer. A memory transfer picks one word by address. A direction bit then decides whether that word is copied into the buffer or the buffer is copied into that word. From the buffer, a store operation writes one of four destination registers, chosen by a 2-bit code. A load operation brings register 1 back into the buffer. A set operation places an external data word into the buffer, so the memory can be filled at all.

Inside a memory transfer, every bit of the word is handled on its own. Each bit takes exactly one of four exclusive routes: a one read in, a zero read in, a one written out, or a zero written out. The route depends on the source bit and the direction bit. Memory bit k always pairs with buffer bit k.

Each operation is one request followed by one completion. The request is accepted only when the unit is idle. The unit then stays busy through a fixed sequence: fetch, apply, complete. A single-cycle done pulse marks the apply result. Requests seen while busy are dropped.

Top module: `xfer_unit`

## Requirements
- R1: After synchronous reset, the following are all zero:
  - the outputs busy and done;
  - the buffer;
  - all four destination registers.
- R2: Operation code 11 (set) loads data_in into the buffer.
- R3: Operation code 00 with rd_mode=1 copies the memory word at addr into the buffer, with bit k going to bit k, for all-zero, all-one and mixed words.
- R4: Operation code 00 with rd_mode=0 writes the buffer into the memory word at addr. The buffer and every other memory word are left unchanged.
- R5: Operation code 01 (store) copies the buffer into the destination named by dsel:
  - 00: register 1;
  - 10: register 2;
  - 01: instruction register;
  - 11: spare register.
  The other three destinations are left unchanged.
- R6: Operation code 10 (load) copies register 1 into the buffer.
- R7: done is high for exactly one cycle. It rises on the third rising edge, counting the edge that accepts the request as the first, and the operation's result is visible in the same cycle.
- R8: busy rises on the accepting edge and falls one cycle after done. A request made while busy is high starts nothing and changes no state. The buffer changes only on the edge where done rises.
- R9: During the apply cycle of a memory transfer, each bit has exactly one of its four routes (read-one, read-zero, write-one, write-zero) enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe; taken only while idle |
| op | input | 2 | 00 memory transfer, 01 store, 10 load, 11 set |
| rd_mode | input | 1 | For memory transfers: 1 memory to buffer, 0 buffer to memory |
| addr | input | AW | Memory word address |
| dsel | input | 2 | Store destination code |
| data_in | input | W | Word for the set operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| buf_q | output | W | Buffer contents |
| reg1_q | output | W | Register 1 |
| reg2_q | output | W | Register 2 |
| instr_q | output | W | Instruction register |
| spare_q | output | W | Spare register, debug visibility only |

## Verification
The bench builds the unit with its defaults: an 8-bit word and a 4-bit address, giving 16 words. Addresses 0 and 15 therefore reach both ends of the memory. Word patterns such as 0x00, 0xFF, 0x5A and 0xC3 drive every bit through both its read and its write routes. Distinct values are kept in register 1, register 2, the instruction register and the spare register. Because of that, a store through the wrong destination code shows up as a changed neighbour.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    OP_MEM   = 2'b00,
    OP_STORE = 2'b01,
    OP_LOAD  = 2'b10,
    OP_SET   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_APPLY,
    ST_DONE
  } st_e;

  // destination codes: bit order is significant to the decoder
  localparam logic [1:0] DST_R1    = 2'b00;
  localparam logic [1:0] DST_INSTR = 2'b01;
  localparam logic [1:0] DST_R2    = 2'b10;
  localparam logic [1:0] DST_SPARE = 2'b11;
endpackage

// File: rtl/xfer_bitpath.sv
// One bit of a memory transfer: four exclusive routes.
module xfer_bitpath (
  input  logic act,
  input  logic rd_mode,
  input  logic mem_bit,
  input  logic buf_bit,
  output logic rd_one,
  output logic rd_zero,
  output logic wr_one,
  output logic wr_zero
);
  always_comb begin
    rd_one  = act &  rd_mode &  mem_bit;
    rd_zero = act &  rd_mode & ~mem_bit;
    wr_one  = act & ~rd_mode &  buf_bit;
    wr_zero = act & ~rd_mode & ~buf_bit;
  end
endmodule

// File: rtl/xfer_dest_bank.sv
// Four buffer-fed destination registers, chosen by a 2-bit code.
module xfer_dest_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [1:0]   dsel,
  input  logic [W-1:0] din,
  output logic [W-1:0] reg1_q,
  output logic [W-1:0] reg2_q,
  output logic [W-1:0] instr_q,
  output logic [W-1:0] spare_q
);
  import xfer_pkg::*;

  localparam int NDST = 4;
  localparam logic [1:0] CODE [NDST] = '{DST_R1, DST_R2, DST_INSTR, DST_SPARE};

  logic [W-1:0] bank [NDST];

  for (genvar d = 0; d < NDST; d++) begin : g_dst
    always_ff @(posedge clk) begin
      if (rst)                          bank[d] <= '0;
      else if (we && dsel == CODE[d])   bank[d] <= din;
    end
  end

  assign reg1_q  = bank[0];
  assign reg2_q  = bank[1];
  assign instr_q = bank[2];
  assign spare_q = bank[3];
endmodule

// File: rtl/xfer_unit.sv
module xfer_unit #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [1:0]    op,
  input  logic          rd_mode,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    dsel,
  input  logic [W-1:0]  data_in,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  buf_q,
  output logic [W-1:0]  reg1_q,
  output logic [W-1:0]  reg2_q,
  output logic [W-1:0]  instr_q,
  output logic [W-1:0]  spare_q
);
  import xfer_pkg::*;

  localparam int DEPTH = 1 << AW;

  st_e           st;
  op_e           op_q;
  logic          mode_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    dsel_q;
  logic [W-1:0]  din_q;

  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  rd_word;
  logic [W-1:0]  wr_word;
  logic [W-1:0]  mem_in;
  logic          xfer_act;
  logic          mem_we;
  logic          store_we;
  logic [W-1:0]  rt, rf, wt, wf;

  assign xfer_act = (st == ST_APPLY) && (op_q == OP_MEM);
  assign mem_we   = xfer_act && !mode_q;
  assign store_we = (st == ST_APPLY) && (op_q == OP_STORE);

  // block-RAM style array: one write port, registered read
  always_ff @(posedge clk) begin
    if (mem_we) mem[addr_q] <= wr_word;
    rd_word <= mem[addr_q];
  end

  for (genvar k = 0; k < W; k++) begin : g_bit
    xfer_bitpath u_path (
      .act     (xfer_act),
      .rd_mode (mode_q),
      .mem_bit (rd_word[k]),
      .buf_bit (buf_q[k]),
      .rd_one  (rt[k]),
      .rd_zero (rf[k]),
      .wr_one  (wt[k]),
      .wr_zero (wf[k])
    );
    assign wr_word[k] = wt[k] ? 1'b1 : (wf[k] ? 1'b0 : rd_word[k]);
    assign mem_in[k]  = rt[k] ? 1'b1 : (rf[k] ? 1'b0 : buf_q[k]);
  end

  xfer_dest_bank #(.W(W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (store_we),
    .dsel    (dsel_q),
    .din     (buf_q),
    .reg1_q  (reg1_q),
    .reg2_q  (reg2_q),
    .instr_q (instr_q),
    .spare_q (spare_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      buf_q  <= '0;
      op_q   <= OP_MEM;
      mode_q <= 1'b0;
      addr_q <= '0;
      dsel_q <= '0;
      din_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req) begin
            op_q   <= op_e'(op);
            mode_q <= rd_mode;
            addr_q <= addr;
            dsel_q <= dsel;
            din_q  <= data_in;
            busy   <= 1'b1;
            st     <= ST_FETCH;
          end
        end
        ST_FETCH: st <= ST_APPLY;
        ST_APPLY: begin
          case (op_q)
            OP_MEM:  if (mode_q) buf_q <= mem_in;
            OP_LOAD: buf_q <= reg1_q;
            OP_SET:  buf_q <= din_q;
            default: ;
          endcase
          done <= 1'b1;
          st   <= ST_DONE;
        end
        default: begin
          done <= 1'b0;
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/xfer_unit_chk.sv
module xfer_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] buf_q,
  input logic         xfer_act,
  input logic [W-1:0] rt,
  input logic [W-1:0] rf,
  input logic [W-1:0] wt,
  input logic [W-1:0] wf
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done)); // R1

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (rst)
    xfer_act |-> (((rt | rf | wt | wf) == {W{1'b1}}) &&
                  (((rt & rf) | (rt & wt) | (rt & wf) |
                    (rf & wt) | (rf & wf) | (wt & wf)) == '0))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> busy); // R8

  AST_BUF_HELD: assert property (@(posedge clk) disable iff (rst)
    !$rose(done) |-> $stable(buf_q)); // R8
endmodule

bind xfer_unit xfer_unit_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .buf_q    (buf_q),
  .xfer_act (xfer_act),
  .rt       (rt),
  .rf       (rf),
  .wt       (wt),
  .wf       (wf)
);

// File: tb/tb_xfer_unit.sv
module tb_xfer_unit;
  localparam int W  = 8;
  localparam int AW = 4;
  localparam int NV = 20;
  // {op[2], mode[1], addr[4], dsel[2], data[8], chk[3], exp[8]}
  // chk: 0 buf, 1 reg1, 2 reg2, 3 instr, 4 spare
  localparam logic [27:0] VEC [NV] = '{
    {2'b11, 1'b0, 4'd0,  2'b00, 8'h5A, 3'd0, 8'h5A},
    {2'b00, 1'b0, 4'd3,  2'b00, 8'h00, 3'd0, 8'h5A},
    {2'b11, 1'b0, 4'd0,  2'b00, 8'hC3, 3'd0, 8'hC3},
    {2'b00, 1'b0, 4'd15, 2'b00, 8'h00, 3'd0, 8'hC3},
    {2'b11, 1'b0, 4'd0,  2'b00, 8'h00, 3'd0, 8'h00},
    {2'b00, 1'b0, 4'd0,  2'b00, 8'h00, 3'd0, 8'h00},
    {2'b00, 1'b1, 4'd3,  2'b00, 8'h00, 3'd0, 8'h5A},
    {2'b01, 1'b0, 4'd0,  2'b00, 8'h00, 3'd1, 8'h5A},
    {2'b00, 1'b1, 4'd15, 2'b00, 8'h00, 3'd0, 8'hC3},
    {2'b01, 1'b0, 4'd0,  2'b10, 8'h00, 3'd2, 8'hC3},
    {2'b01, 1'b0, 4'd0,  2'b10, 8'h00, 3'd1, 8'h5A},
    {2'b11, 1'b0, 4'd0,  2'b00, 8'hFF, 3'd0, 8'hFF},
    {2'b00, 1'b0, 4'd7,  2'b00, 8'h00, 3'd0, 8'hFF},
    {2'b01, 1'b0, 4'd0,  2'b01, 8'h00, 3'd3, 8'hFF},
    {2'b11, 1'b0, 4'd0,  2'b00, 8'h0F, 3'd0, 8'h0F},
    {2'b01, 1'b0, 4'd0,  2'b11, 8'h00, 3'd4, 8'h0F},
    {2'b01, 1'b0, 4'd0,  2'b11, 8'h00, 3'd3, 8'hFF},
    {2'b00, 1'b1, 4'd7,  2'b00, 8'h00, 3'd0, 8'hFF},
    {2'b00, 1'b1, 4'd0,  2'b00, 8'h00, 3'd0, 8'h00},
    {2'b10, 1'b0, 4'd0,  2'b00, 8'h00, 3'd0, 8'h5A}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [1:0]    op = 2'b00;
  logic          rd_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    dsel = 2'b00;
  logic [W-1:0]  data_in = '0;
  logic          busy, done;
  logic [W-1:0]  buf_q, reg1_q, reg2_q, instr_q, spare_q;

  int n_chk = 0;
  int n_fail = 0;

  xfer_unit #(.W(W), .AW(AW)) dut (
    .clk(clk), .rst(rst), .req(req), .op(op), .rd_mode(rd_mode),
    .addr(addr), .dsel(dsel), .data_in(data_in),
    .busy(busy), .done(done), .buf_q(buf_q), .reg1_q(reg1_q),
    .reg2_q(reg2_q), .instr_q(instr_q), .spare_q(spare_q)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pick(input logic [2:0] c);
    case (c)
      3'd1:    return reg1_q;
      3'd2:    return reg2_q;
      3'd3:    return instr_q;
      3'd4:    return spare_q;
      default: return buf_q;
    endcase
  endfunction

  // drive at a falling edge; returns falling edges until done was seen
  task automatic run(input logic [1:0] o, input logic m, input logic [AW-1:0] a,
                     input logic [1:0] d, input logic [W-1:0] v, output int lat);
    @(negedge clk);
    op = o; rd_mode = m; addr = a; dsel = d; data_in = v; req = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      req = 1'b0;
      lat++;
    end while (!done && lat < 10);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {7'b0, busy}, 8'h00);
    chk("R1 done", {7'b0, done}, 8'h00);
    chk("R1 buf", buf_q, 8'h00);
    chk("R1 regs", reg1_q | reg2_q | instr_q | spare_q, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] e;
      string tag;
      e = VEC[i];
      case (e[27:26])
        2'b11:   tag = "R2 set";
        2'b00:   tag = e[25] ? "R3 mem read" : "R4 mem write";
        2'b01:   tag = "R5 store";
        default: tag = "R6 load";
      endcase
      run(e[27:26], e[25], e[24:21], e[20:19], e[18:11], lat);
      chk($sformatf("R7 latency v%0d", i), lat[W-1:0], 8'd3);
      chk($sformatf("%s v%0d", tag, i), pick(e[10:8]), e[7:0]);
      @(negedge clk);
      chk($sformatf("R7 done drop v%0d", i), {7'b0, done}, 8'h00);
      chk($sformatf("R8 busy drop v%0d", i), {7'b0, busy}, 8'h00);
    end

    // R8 request during busy is dropped
    @(negedge clk);
    op = 2'b11; data_in = 8'h11; req = 1'b1;
    @(negedge clk);
    chk("R8 busy on accept", {7'b0, busy}, 8'h01);
    data_in = 8'hEE; op = 2'b11;
    @(negedge clk);
    @(negedge clk);
    chk("R7 done pulse", {7'b0, done}, 8'h01);
    chk("R8 held-off buf", buf_q, 8'h11);
    req = 1'b0;
    begin
      int extra = 0;
      repeat (6) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R8 no extra done", extra[W-1:0], 8'h00);
    end
    chk("R8 buf unchanged", buf_q, 8'h11);
    chk("R8 reg1 unchanged", reg1_q, 8'h5A);

    // R4 other words intact after writes
    run(2'b00, 1'b1, 4'd15, 2'b00, 8'h00, lat);
    chk("R4 addr15 intact", buf_q, 8'hC3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule